// File: doc/BRIEF.md
# Chainable Debug Event Counter Pair

Two event counters sit on a 256-line event bus. Each counter has its own control word that picks one bus line, a running count and an interval word, all reached through a small word-addressed read/write port. A counter either counts rising edges of its line (occurrence mode) or counts every clock in which the line is high (duration mode). When the next count value equals a non-zero interval, the counter can raise a one-cycle interrupt pulse, raise a one-cycle debug pulse, latch a sticky debug status bit, and either wrap to zero or stop.

The odd counter can be chained behind the even one to form a 64-bit count. It then advances only when the even counter rolls over. A shadow copy of the odd counter, taken when the even counter is read, keeps a low-then-high read pair coherent. In watchdog mode a counter waits for a start event, counts clock cycles, is pulled back to zero by a second selected event, and fires its interval actions only if no such event arrives in time.

Each counter runs a four-state machine. OFF: the enable bit is clear and the count holds. OFF goes to ARM when enabled in watchdog mode and to RUN otherwise. ARM: the counter waits for a rising edge of the start event, which clears the count and moves it to RUN. A counter in ARM with watchdog mode cleared also goes to RUN. RUN: the counter advances. A match without restart moves it to DONE. DONE: the count holds at the interval until the clear bit is written, which returns it to ARM or RUN. Clearing the enable bit returns any state to OFF.

Top module: `dbg_evt_ctr_pair`

## Requirements
- R1: After reset every control, count and interval word reads zero and both pulse outputs are low. Control bits 5:4 always read zero. Bits 6, 7 and 13 to 15 are stored and read back as written.
- R2: In occurrence mode (control bit 3 = 0) with enable (bit 0) set, the count rises by one per rising edge of the bus line chosen by bits 23:16. Other lines have no effect.
- R3: In duration mode (bit 3 = 1) the count rises by one on every clock edge at which the chosen line is high.
- R4: Writing 1 to control bit 1 zeroes the count at the following clock edge, and bit 1 reads back as 0 from then on.
- R5: A match occurs when a step would make the count equal to a non-zero interval. With bit 8 set, `irq` for that counter is high for exactly the one cycle after the matching edge. With bit 9 set, `dbg_evt` behaves the same way. An interval of 0 never matches.
- R6: On a match with bit 10 set the count becomes 0 and counting continues. With bit 10 clear the count stays at the interval and ignores events until bit 1 is written.
- R7: Control bit 12 becomes 1 on a match while bit 9 is set. Writing 1 to bit 12 clears it, and writing 0 leaves it unchanged.
- R8: With chain (bit 2) set on counter 1, counter 1 advances only when counter 0 steps from all ones to zero. Its own selected event line is ignored.
- R9: With bit 7 set in control word 0 and counter 1 chained, a read of count 0 copies count 1 into a shadow register, and reads of count 1 return that shadow. With bit 7 clear, reads of count 1 return the live value.
- R10: In watchdog mode (bit 11) the count stays put until a rising edge on the line picked by bits 23:16. After that edge it rises every clock, returns to 0 on a rising edge of the line picked by bits 31:24, and produces the R5/R6 match actions on reaching the interval.
- R11: Word addresses are: 0 control 0, 1 control 1, 2 count 0, 3 count 1, 4 interval 0, 5 interval 1. Counts and intervals are writable. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_bus | input | 256 | Event lines to choose from |
| reg_wr | input | 1 | Write strobe, takes effect at the clock edge |
| reg_rd | input | 1 | Read strobe; a read of address 2 updates the shadow |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 2 | Per-counter interrupt pulse |
| dbg_evt | output | 2 | Per-counter debug pulse |

## Verification
A counter whose state machine sits in the wrong state shows up in the count read on the next access. It either advances when it should hold (DONE, ARM) or holds when it should advance. A wrong match decision shows as an `irq` or `dbg_evt` pulse in the cycle right after the deciding edge, or as a missing pulse, and as a count that is not zero after a restart. A stale or missing shadow capture is seen on the very next read of count 1. A lost carry is seen as a high word that stays flat after a rollover of the low word.

// File: rtl/dbgctr_pkg.sv
`timescale 1ns/1ps
package dbgctr_pkg;

    localparam int SEL_W   = 8;
    localparam int NUM_EVT = 1 << SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] wdr_sel;   // watchdog clear event
        logic [SEL_W-1:0] evt_sel;   // counted / start event
        logic [1:0]       mode_sel;  // stored only
        logic             filt;      // stored only
        logic             trig_st;   // sticky debug status
        logic             wd;
        logic             restart;
        logic             dbg_en;
        logic             int_en;
        logic             shadow;
        logic             ovf;       // stored only
        logic [1:0]       rsvd;
        logic             dur;
        logic             chain;
        logic             clr;
        logic             en;
    } ctrl_t;

    localparam int DATA_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_ARM  = 2'd1,
        S_RUN  = 2'd2,
        S_DONE = 2'd3
    } ctr_state_e;

    localparam int A_CTRL0 = 0;
    localparam int A_CNT0  = 2;
    localparam int A_IVL0  = 4;

endpackage

// File: rtl/dbgctr_evt_pick.sv
`timescale 1ns/1ps
module dbgctr_evt_pick
    import dbgctr_pkg::*;
#(
    parameter int PSEL_W = SEL_W,
    localparam int PNUM = 1 << PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PNUM-1:0]   evt_bus,
    input  logic [PSEL_W-1:0] sel,
    output logic              level,
    output logic              rise
);

    logic prev_q;

    assign level = evt_bus[sel];
    assign rise  = level & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

endmodule

// File: rtl/dbgctr_unit.sv
`timescale 1ns/1ps
module dbgctr_unit
    import dbgctr_pkg::*;
#(
    parameter int CNT_W = DATA_W,
    parameter bit ODD   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             cnt_lvl,
    input  logic             cnt_rise,
    input  logic             wdr_rise,
    input  logic             carry_in,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] ivl,
    output logic [CNT_W-1:0] cnt,
    output logic             carry_out,
    output logic             hit,
    output logic             irq_o,
    output logic             dbg_o
);

    ctr_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_inc;
    logic chained, inc, running, wd_kick, step, start;
    logic unused_fields;

    assign unused_fields = ^{ctrl.wdr_sel, ctrl.evt_sel, ctrl.mode_sel, ctrl.filt,
                             ctrl.trig_st, ctrl.shadow, ctrl.ovf, ctrl.rsvd};

    generate
        if (ODD) begin : g_chain
            assign chained = ctrl.chain;
        end else begin : g_nochain
            assign chained = 1'b0;
        end
    endgenerate

    always_comb begin
        if (ctrl.wd)      inc = 1'b1;
        else if (chained) inc = carry_in;
        else if (ctrl.dur) inc = cnt_lvl;
        else              inc = cnt_rise;
    end

    assign running   = (st_q == S_RUN);
    assign wd_kick   = ctrl.wd && wdr_rise;
    assign start     = (st_q == S_ARM) && ctrl.wd && cnt_rise;
    assign step      = running && inc && !wd_kick;
    assign cnt_inc   = cnt_q + 1'b1;
    assign hit       = step && (ivl != '0) && (cnt_inc == ivl) && !cnt_wr && !ctrl.clr;
    assign carry_out = step && (cnt_q == {CNT_W{1'b1}});
    assign cnt       = cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!ctrl.en) begin
            st_d = S_OFF;
        end else begin
            unique case (st_q)
                S_OFF:  st_d = ctrl.wd ? S_ARM : S_RUN;
                S_ARM:  if (!ctrl.wd || cnt_rise) st_d = S_RUN;
                S_RUN:  if (hit && !ctrl.restart) st_d = S_DONE;
                S_DONE: if (ctrl.clr) st_d = ctrl.wd ? S_ARM : S_RUN;
                default: st_d = S_OFF;
            endcase
        end
    end

    // count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (cnt_wr)             cnt_q <= cnt_wdata;
        else if (ctrl.clr)           cnt_q <= '0;
        else if (start)              cnt_q <= '0;
        else if (running && wd_kick) cnt_q <= '0;
        else if (hit && ctrl.restart) cnt_q <= '0;
        else if (step)               cnt_q <= cnt_inc;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            dbg_o <= 1'b0;
        end else begin
            irq_o <= hit && ctrl.int_en;
            dbg_o <= hit && ctrl.dbg_en;
        end
    end

endmodule

// File: rtl/dbg_evt_ctr_pair.sv
`timescale 1ns/1ps
module dbg_evt_ctr_pair
    import dbgctr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_bus,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [1:0]         irq,
    output logic [1:0]         dbg_evt
);

    localparam int NCTR = 2;

    ctrl_t [NCTR-1:0]             ctrl_all;
    logic  [NCTR-1:0][DATA_W-1:0] cnt_all;
    logic  [NCTR-1:0][DATA_W-1:0] ivl_all;
    logic  [NCTR-1:0]             carry_w;
    logic  [NCTR-1:0]             hit_w;
    logic  [DATA_W-1:0]           shadow_q;
    logic                         shadow_on;
    logic                         unused_top;

    assign unused_top = carry_w[NCTR-1];

    generate
        for (genvar i = 0; i < NCTR; i++) begin : g_ctr
            ctrl_t             ctrl_r, ctrl_d, wview;
            logic [DATA_W-1:0] ivl_r;
            logic              lvl, rise, wdr_lvl, wdr_rise, cin;
            logic              wr_ctrl, wr_cnt, wr_ivl;

            assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL0 + i));
            assign wr_cnt  = reg_wr && (reg_addr == ADDR_W'(A_CNT0 + i));
            assign wr_ivl  = reg_wr && (reg_addr == ADDR_W'(A_IVL0 + i));
            assign wview   = ctrl_t'(reg_wdata);

            if (i == 0) begin : g_low
                assign cin = 1'b0;
            end else begin : g_high
                assign cin = carry_w[i-1];
            end

            always_comb begin
                ctrl_d = ctrl_r;
                if (ctrl_r.clr) ctrl_d.clr = 1'b0;
                if (wr_ctrl) begin
                    ctrl_d         = wview;
                    ctrl_d.rsvd    = '0;
                    ctrl_d.trig_st = ctrl_r.trig_st & ~wview.trig_st;
                end
                if (hit_w[i] && ctrl_r.dbg_en) ctrl_d.trig_st = 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctrl_r <= '0;
                    ivl_r  <= '0;
                end else begin
                    ctrl_r <= ctrl_d;
                    if (wr_ivl) ivl_r <= reg_wdata;
                end
            end

            assign ctrl_all[i] = ctrl_r;
            assign ivl_all[i]  = ivl_r;

            dbgctr_evt_pick #(.PSEL_W(SEL_W)) u_sel (
                .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus),
                .sel(ctrl_r.evt_sel), .level(lvl), .rise(rise)
            );

            dbgctr_evt_pick #(.PSEL_W(SEL_W)) u_wdr (
                .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus),
                .sel(ctrl_r.wdr_sel), .level(wdr_lvl), .rise(wdr_rise)
            );

            dbgctr_unit #(.CNT_W(DATA_W), .ODD((i % 2) == 1)) u_unit (
                .clk(clk), .rst_n(rst_n), .ctrl(ctrl_r),
                .cnt_lvl(lvl), .cnt_rise(rise), .wdr_rise(wdr_rise),
                .carry_in(cin), .cnt_wr(wr_cnt), .cnt_wdata(reg_wdata),
                .ivl(ivl_r), .cnt(cnt_all[i]), .carry_out(carry_w[i]),
                .hit(hit_w[i]), .irq_o(irq[i]), .dbg_o(dbg_evt[i])
            );
        end
    endgenerate

    assign shadow_on = ctrl_all[0].shadow && ctrl_all[1].chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else if (reg_rd && shadow_on && (reg_addr == ADDR_W'(A_CNT0)))
            shadow_q <= cnt_all[1];
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(A_CTRL0):     reg_rdata = ctrl_all[0];
            ADDR_W'(A_CTRL0 + 1): reg_rdata = ctrl_all[1];
            ADDR_W'(A_CNT0):      reg_rdata = cnt_all[0];
            ADDR_W'(A_CNT0 + 1):  reg_rdata = shadow_on ? shadow_q : cnt_all[1];
            ADDR_W'(A_IVL0):      reg_rdata = ivl_all[0];
            ADDR_W'(A_IVL0 + 1):  reg_rdata = ivl_all[1];
            default:              reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbgctr_chk.sv
`timescale 1ns/1ps
module dbgctr_chk
    import dbgctr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input ctrl_t             ctrl0,
    input ctrl_t             ctrl1,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] cnt1,
    input logic [DATA_W-1:0] ivl0,
    input logic [1:0]        irq,
    input logic [1:0]        dbg_evt
);

    logic unused_chk;
    assign unused_chk = ^{reg_addr, ctrl0, ctrl1};

    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0.rsvd == 2'b00) && (ctrl1.rsvd == 2'b00));

    a_r4_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0.clr && !reg_wr) |=> (cnt0 == '0) && !ctrl0.clr);

    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> $past(ctrl0.int_en));

    a_r5_dbg_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt[0] |-> $past(ctrl0.dbg_en));

    a_r6_irq_at_ivl: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && !$past(reg_wr)) |-> ((cnt0 == ivl0) || (cnt0 == '0)));

    a_r7_stat_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl0.trig_st) |-> dbg_evt[0]);

    a_r8_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl1.chain) && !$past(ctrl1.wd) && !$past(reg_wr) && !$past(ctrl1.clr)
         && (cnt1 != $past(cnt1))) |-> ($past(cnt0) == {DATA_W{1'b1}}));

endmodule

bind dbg_evt_ctr_pair dbgctr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .ctrl0(ctrl_all[0]), .ctrl1(ctrl_all[1]),
    .cnt0(cnt_all[0]), .cnt1(cnt_all[1]), .ivl0(ivl_all[0]),
    .irq(irq), .dbg_evt(dbg_evt)
);

// File: tb/tb_dbg_evt_ctr_pair.sv
`timescale 1ns/1ps
module tb_dbg_evt_ctr_pair;

    localparam logic [31:0] C_EN = 32'h1, C_CLR = 32'h2, C_CHAIN = 32'h4, C_DUR = 32'h8;
    localparam logic [31:0] C_SHD = 32'h80, C_INT = 32'h100, C_DBG = 32'h200;
    localparam logic [31:0] C_RST = 32'h400, C_WD = 32'h800, C_STAT = 32'h1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] evt_bus = '0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [1:0]   irq, dbg_evt;

    int n_chk = 0, n_bad = 0, irq_n = 0, dbg_n = 0;
    bit done = 1'b0;

    dbg_evt_ctr_pair dut (
        .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dbg_evt(dbg_evt)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (irq[0]) irq_n++;
        if (dbg_evt[0]) dbg_n++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx, input int len);
        @(negedge clk); evt_bus[idx] = 1'b1;
        repeat (len) @(negedge clk);
        evt_bus[idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 R11 reset word %0d", a), v, 32'h0);
        end
        chk("R1 pulses low", {30'h0, irq | dbg_evt}, 32'h0);
        wr(3'd1, 32'h0000_E0F0);
        rd(3'd1, v);
        chk("R1 reserved bits", v, 32'h0000_E0C0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_occurrence();
        logic [31:0] v;
        wr(3'd0, C_EN | (32'd5 << 16));
        idle(2);
        pulse(5, 3);
        idle(2);
        pulse(5, 1);
        idle(1);
        rd(3'd2, v);
        chk("R2 occurrence count", v, 32'd2);
        pulse(6, 2);
        idle(1);
        rd(3'd2, v);
        chk("R2 other line ignored", v, 32'd2);
    endtask

    task automatic t_duration();
        logic [31:0] v;
        wr(3'd2, 32'd50);
        rd(3'd2, v);
        chk("R11 count write", v, 32'd50);
        wr(3'd0, C_EN | C_CLR | C_DUR | (32'd5 << 16));
        rd(3'd0, v);
        chk("R4 clear bit self-clears", v & C_CLR, 32'h0);
        rd(3'd2, v);
        chk("R4 count cleared", v, 32'd0);
        pulse(5, 4);
        idle(1);
        rd(3'd2, v);
        chk("R3 duration count", v, 32'd4);
    endtask

    task automatic t_match();
        logic [31:0] v;
        int i0, d0;
        wr(3'd0, 32'h0);
        wr(3'd4, 32'd3);
        wr(3'd0, C_EN | C_CLR | C_INT | C_DBG | C_RST | (32'd5 << 16));
        idle(2);
        i0 = irq_n; d0 = dbg_n;
        pulse(5, 1); pulse(5, 1);
        idle(1);
        chk("R5 no pulse before match", irq_n - i0, 0);
        rd(3'd2, v);
        chk("R5 count before match", v, 32'd2);
        pulse(5, 1);
        idle(2);
        chk("R5 irq one cycle", irq_n - i0, 1);
        chk("R5 dbg one cycle", dbg_n - d0, 1);
        rd(3'd2, v);
        chk("R6 restart to zero", v, 32'd0);
        rd(3'd0, v);
        chk("R7 status set", v & C_STAT, C_STAT);
        wr(3'd0, C_EN | C_INT | C_DBG | C_RST | (32'd5 << 16));
        rd(3'd0, v);
        chk("R7 write 0 keeps status", v & C_STAT, C_STAT);
        wr(3'd0, C_STAT | C_EN | C_INT | C_DBG | C_RST | (32'd5 << 16));
        rd(3'd0, v);
        chk("R7 write 1 clears status", v & C_STAT, 32'h0);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        int i0, d0;
        wr(3'd0, 32'h0);
        wr(3'd0, C_EN | C_CLR | C_INT | (32'd5 << 16));
        idle(2);
        i0 = irq_n; d0 = dbg_n;
        repeat (5) pulse(5, 1);
        idle(2);
        rd(3'd2, v);
        chk("R6 holds at interval", v, 32'd3);
        chk("R6 single irq", irq_n - i0, 1);
        chk("R5 dbg off no pulse", dbg_n - d0, 0);
        rd(3'd0, v);
        chk("R7 status needs dbg", v & C_STAT, 32'h0);
        wr(3'd0, C_EN | C_CLR | C_INT | (32'd5 << 16));
        idle(2);
        pulse(5, 1);
        idle(1);
        rd(3'd2, v);
        chk("R6 clear resumes", v, 32'd1);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd4, 32'h0); wr(3'd5, 32'h0);
        wr(3'd2, 32'hFFFF_FFFE); wr(3'd3, 32'd7);
        wr(3'd1, C_EN | C_CHAIN);
        wr(3'd0, C_EN | C_DUR | C_SHD | (32'd7 << 16));
        idle(1);
        pulse(0, 2);
        idle(1);
        pulse(7, 3);
        idle(1);
        rd(3'd2, v);
        chk("R8 low word after wrap", v, 32'd1);
        rd(3'd3, v);
        chk("R8 high word one carry", v, 32'd8);
        wr(3'd3, 32'd100);
        rd(3'd3, v);
        chk("R9 shadow keeps latched", v, 32'd8);
        rd(3'd2, v);
        rd(3'd3, v);
        chk("R9 shadow relatched", v, 32'd100);
        wr(3'd0, C_EN | C_DUR | (32'd7 << 16));
        wr(3'd3, 32'd55);
        rd(3'd3, v);
        chk("R9 live read without shadow", v, 32'd55);
    endtask

    task automatic t_watchdog();
        logic [31:0] v;
        int i0;
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd4, 32'd20);
        wr(3'd0, C_EN | C_CLR | C_WD | C_INT | (32'd10 << 16) | (32'd11 << 24));
        idle(5);
        rd(3'd2, v);
        chk("R10 idle before start", v, 32'd0);
        i0 = irq_n;
        pulse(10, 1);
        idle(7);
        rd(3'd2, v);
        chk("R10 counts after start", v, 32'd8);
        pulse(11, 1);
        idle(11);
        rd(3'd2, v);
        chk("R10 clear event restarts", v, 32'd12);
        chk("R10 no early fire", irq_n - i0, 0);
        idle(12);
        rd(3'd2, v);
        chk("R10 fires at interval", v, 32'd20);
        chk("R10 irq once", irq_n - i0, 1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_occurrence();
        t_duration();
        t_match();
        t_halt();
        t_chain();
        t_watchdog();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all R act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule